// File: doc/BRIEF.md
# Dual-Bank Histogram Engine

The block counts how often each 8-bit sample value occurs in a stream that can deliver one sample per clock. Each value addresses one of 256 bins of 64 bits. The counts live in two single-port banks. Accepted samples go to the two banks in turn. Incrementing a bin takes a read and then a write, but because each bank gets at most every other sample, the stream never has to stall.

The sample value is used directly as the bin number. For signed sources, bin 255 stands for -1 in two's complement. A 2-bit mode input drives the block through four modes:

- **RESET** puts the control state back to its starting values.
- **CLEAR** sweeps both banks and writes zero to every bin.
- **RUN** logs samples.
- **FREEZE** stops all updates so that software can read the results.

In FREEZE a read address selects a bin. One cycle later the block returns the sum of both banks at that address. A running 64-bit total of all logged samples is also kept. Every 64-bit result is presented as an upper and a lower 32-bit word.

The sample input is a valid/ready stream. Ready is high only in RUN, and a sample is taken in any cycle where valid and ready are both high. Ready does not depend on valid. A source that holds valid while ready is low simply waits; nothing is logged or lost.

Top module: `hist_engine`

## Requirements
- R1: `smp_ready` is 1 exactly when mode is RUN. A sample is logged only in a cycle where `smp_valid` and `smp_ready` are both 1. In every other mode the stream input has no effect on the bins or the total.
- R2: The mode encoding is RESET=2'b00, CLEAR=2'b01, RUN=2'b10 and FREEZE=2'b11. One clock in RESET, or with `rst_n` low, sets the total to zero and `clear_done` to 0, and cancels any pending increment.
- R3: After 256 clocks in CLEAR, every bin of both banks holds zero. `clear_done` is 0 after 255 such clocks and 1 after 256. It then stays 1 until the next RESET.
- R4: Each logged sample adds exactly one to the bin whose address equals the sample value, with values 0 to 255 (255 being -1 in two's complement). Back-to-back samples with the same value are all counted.
- R5: In FREEZE, the value of `rd_addr` at one clock edge selects a bin. After that edge, `{bin_hi, bin_lo}` equals that bin's count, summed over both banks. `bin_valid` is 1 after an edge at which mode was FREEZE, and 0 otherwise.
- R6: `{total_hi, total_lo}` equals the number of samples logged since the last RESET. Each 64-bit result is split with bits 63:32 in the `_hi` word and bits 31:0 in the `_lo` word.
- R7: While in FREEZE, the total and every bin stay unchanged, even when `smp_valid` is held high.
- R8: A sample logged in the last RUN cycle is visible to a bin read issued in the first FREEZE cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Operating mode (see R2) |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, high in RUN |
| smp_data | input | 8 | Sample value, used as the bin address |
| rd_addr | input | 8 | Bin to read in FREEZE |
| bin_valid | output | 1 | Bin read result is valid |
| bin_hi | output | 32 | Upper word of the bin count |
| bin_lo | output | 32 | Lower word of the bin count |
| total_hi | output | 32 | Upper word of the sample total |
| total_lo | output | 32 | Lower word of the sample total |
| clear_done | output | 1 | Clear sweep has finished |

## Verification
The assertions take for granted that `mode` is a clean, synchronous input that changes only between clock edges. They also assume that `rd_addr` matters only in FREEZE, and that the total never wraps past 64 bits.

The stimulus respects these assumptions:
- It drives every input on the falling edge.
- It passes through RESET and a complete CLEAR sweep before any RUN phase.
- It reads bins only while frozen.
- It keeps total counts far below any overflow.

Random sample values are biased towards a few repeated values, including 0 and 255, so that back-to-back hits on the same bin in the same bank and in the other bank occur often.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    MODE_RESET  = 2'b00,
    MODE_CLEAR  = 2'b01,
    MODE_RUN    = 2'b10,
    MODE_FREEZE = 2'b11
  } hist_mode_e;
endpackage

// File: rtl/hist_bank.sv
module hist_bank #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              flush,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic              inc_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CNT_W-1:0]  mem [DEPTH];
  logic              p_vld;
  logic [ADDR_W-1:0] p_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [CNT_W-1:0]  wr_data;

  // clear sweep wins over a pending write-back
  always_comb begin
    wr_en   = clr_en | p_vld;
    wr_addr = clr_en ? clr_addr : p_addr;
    wr_data = clr_en ? '0 : rd_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // read port, forwarding a write to the same address in the same cycle
  always_ff @(posedge clk) begin
    if (rd_en) begin
      if (wr_en && (wr_addr == addr)) rd_q <= wr_data;
      else                            rd_q <= mem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (flush) begin
      p_vld  <= 1'b0;
      p_addr <= '0;
    end else begin
      p_vld  <= inc_en & ~clr_en;
      if (inc_en) p_addr <= addr;
    end
  end
endmodule

// File: rtl/hist_clear_seq.sv
module hist_clear_seq #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              flush,
  input  logic              active,
  output logic              clr_en,
  output logic [ADDR_W-1:0] clr_addr,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  assign clr_en = active & ~done;

  always_ff @(posedge clk) begin
    if (flush) begin
      clr_addr <= '0;
      done     <= 1'b0;
    end else if (clr_en) begin
      clr_addr <= clr_addr + ADDR_W'(1);
      if (clr_addr == LAST) done <= 1'b1;
    end
  end
endmodule

// File: rtl/hist_engine.sv
module hist_engine #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic [ADDR_W-1:0]    smp_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 bin_valid,
  output logic [CNT_W/2-1:0]   bin_hi,
  output logic [CNT_W/2-1:0]   bin_lo,
  output logic [CNT_W/2-1:0]   total_hi,
  output logic [CNT_W/2-1:0]   total_lo,
  output logic                 clear_done
);
  import hist_pkg::*;
  localparam int HALF   = CNT_W / 2;
  localparam int NBANKS = 2;

  hist_mode_e        md;
  logic              flush;
  logic              accept;
  logic              sel;
  logic [CNT_W-1:0]  total;
  logic [CNT_W-1:0]  bin_sum;
  logic              clr_en;
  logic [ADDR_W-1:0] clr_addr;
  logic              frz;
  logic [ADDR_W-1:0] bank_addr;
  logic [CNT_W-1:0]  bank_q [NBANKS];

  assign md        = hist_mode_e'(mode);
  assign flush     = !rst_n || (md == MODE_RESET);
  assign frz       = (md == MODE_FREEZE);
  assign smp_ready = (md == MODE_RUN);
  assign accept    = smp_valid & smp_ready;
  assign bank_addr = frz ? rd_addr : smp_data;

  always_ff @(posedge clk) begin
    if (flush) begin
      sel   <= 1'b0;
      total <= '0;
    end else if (accept) begin
      sel   <= ~sel;
      total <= total + CNT_W'(1);
    end
  end

  hist_clear_seq #(.ADDR_W(ADDR_W)) u_clr (
    .clk      (clk),
    .flush    (flush),
    .active   (md == MODE_CLEAR),
    .clr_en   (clr_en),
    .clr_addr (clr_addr),
    .done     (clear_done)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic inc;
    assign inc = accept && (sel == b[0]);
    hist_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .flush    (flush),
      .clr_en   (clr_en),
      .clr_addr (clr_addr),
      .inc_en   (inc),
      .rd_en    (inc | frz),
      .addr     (bank_addr),
      .rd_q     (bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (flush) bin_valid <= 1'b0;
    else       bin_valid <= frz;
  end

  assign bin_sum  = bank_q[0] + bank_q[1];
  assign bin_hi   = bin_sum[CNT_W-1:HALF];
  assign bin_lo   = bin_sum[HALF-1:0];
  assign total_hi = total[CNT_W-1:HALF];
  assign total_lo = total[HALF-1:0];
endmodule

// File: rtl/hist_engine_chk.sv
module hist_engine_chk #(
  parameter int HALF = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic            smp_valid,
  input logic            smp_ready,
  input logic            bin_valid,
  input logic [HALF-1:0] total_hi,
  input logic [HALF-1:0] total_lo,
  input logic            clear_done
);
  logic [2*HALF-1:0] tot;
  assign tot = {total_hi, total_lo};

  p_no_log_outside_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10 && mode != 2'b00) |=> $stable(tot));

  p_reset_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (tot == '0 && !clear_done));

  p_done_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_done && mode != 2'b00) |=> clear_done);

  p_bin_valid_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bin_valid |-> ($past(mode) == 2'b11));

  p_total_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && mode == 2'b10) |=> (tot == $past(tot) + 1));

  p_freeze_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> !smp_ready);
endmodule

bind hist_engine hist_engine_chk #(.HALF(CNT_W/2)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .smp_valid  (smp_valid),
  .smp_ready  (smp_ready),
  .bin_valid  (bin_valid),
  .total_hi   (total_hi),
  .total_lo   (total_lo),
  .clear_done (clear_done)
);

// File: tb/sim_hist_engine.sv
module sim_hist_engine;
  localparam logic [1:0] M_RST = 2'b00, M_CLR = 2'b01, M_RUN = 2'b10, M_FRZ = 2'b11;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  mode = M_RST;
  logic        smp_valid = 0;
  logic        smp_ready;
  logic [7:0]  smp_data = 0;
  logic [7:0]  rd_addr = 0;
  logic        bin_valid;
  logic [31:0] bin_hi, bin_lo, total_hi, total_lo;
  logic        clear_done;

  int checks = 0, fails = 0;
  longint unsigned exp_bin [256];
  longint unsigned exp_total = 0;

  always #10 clk = ~clk;

  hist_engine u0 (.*);

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] pick();
    int r = $urandom % 8;
    case (r)
      0: return 8'd0;
      1: return 8'd255;
      2, 3: return 8'd7;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic do_reset_clear(string tag);
    mode = M_RST; tick();
    check({tag, " R2 total"}, {total_hi, total_lo}, 0);
    check({tag, " R2 clear_done"}, clear_done, 0);
    mode = M_CLR;
    for (int i = 0; i < 255; i++) tick();
    check({tag, " R3 done after 255"}, clear_done, 0);
    tick();
    check({tag, " R3 done after 256"}, clear_done, 1);
    tick();
    check({tag, " R3 done holds"}, clear_done, 1);
    for (int i = 0; i < 256; i++) exp_bin[i] = 0;
    exp_total = 0;
  endtask

  task automatic read_all(string tag);
    int bad = 0;
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a); tick();
      checks++;
      if ({bin_hi, bin_lo} !== exp_bin[a] || bin_valid !== 1'b1) begin
        bad++; fails++;
        $display("FAIL %s R4/R5 bin %0d actual=%0d expected=%0d", tag, a, {bin_hi, bin_lo}, exp_bin[a]);
      end
    end
  endtask

  task automatic run_random(int n);
    mode = M_RUN;
    for (int i = 0; i < n; i++) begin
      smp_valid = ($urandom % 4) != 0;
      smp_data  = pick();
      if (smp_valid) begin
        exp_bin[smp_data]++;
        exp_total++;
      end
      tick();
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    tick(); tick();
    check("R1 ready in reset", smp_ready, 0);
    check("R5 bin_valid in reset", bin_valid, 0);
    rst_n = 1;
    do_reset_clear("phase1");
    check("R1 ready in clear", smp_ready, 0);

    // directed: same value back to back, then edges of range
    mode = M_RUN; smp_valid = 1;
    check("R1 ready in run", smp_ready, 1);
    for (int i = 0; i < 5; i++) begin smp_data = 8'd200; exp_bin[200]++; exp_total++; tick(); end
    smp_data = 8'd255; exp_bin[255]++; exp_total++; tick();
    smp_data = 8'd0;   exp_bin[0]++;   exp_total++; tick();
    run_random(900);
    // R8: last RUN sample then immediate freeze and read of same bin
    smp_valid = 1; smp_data = 8'd99; exp_bin[99]++; exp_total++;
    tick();
    mode = M_FRZ; smp_valid = 0; rd_addr = 8'd99;
    tick();
    check("R8 last sample visible", {bin_hi, bin_lo}, exp_bin[99]);
    check("R5 bin_valid freeze", bin_valid, 1);
    check("R6 total", {total_hi, total_lo}, exp_total);
    check("R6 total_hi zero", total_hi, 0);
    read_all("phase1");

    // R7: valid held high in freeze
    smp_valid = 1; smp_data = 8'd7;
    check("R1/R7 ready low in freeze", smp_ready, 0);
    for (int i = 0; i < 20; i++) tick();
    smp_valid = 0;
    check("R7 total stable", {total_hi, total_lo}, exp_total);
    rd_addr = 8'd7; tick();
    check("R7 bin 7 stable", {bin_hi, bin_lo}, exp_bin[7]);

    // R1: valid in clear mode has no effect on total
    mode = M_CLR; smp_valid = 1; smp_data = 8'd3; tick(); tick();
    smp_valid = 0;
    check("R1 no log in clear", {total_hi, total_lo}, exp_total);
    mode = M_FRZ; tick();
    check("R5 bin_valid after leaving freeze then back", bin_valid, 1);
    mode = M_RUN; tick();
    check("R5 bin_valid low outside freeze", bin_valid, 0);

    // phase 2: reset, clear, single-value stream every cycle
    do_reset_clear("phase2");
    mode = M_RUN; smp_valid = 1; smp_data = 8'd128;
    for (int i = 0; i < 301; i++) begin exp_bin[128]++; exp_total++; tick(); end
    run_random(300);
    smp_valid = 0; mode = M_FRZ; tick();
    check("phase2 R6 total", {total_hi, total_lo}, exp_total);
    read_all("phase2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule